// File: doc/BRIEF.md
# Buffered Compare PWM Timer

This block is a free-running up-counter that drives one pulse-width-modulated output. The period is one of three power-of-two lengths: the counter runs from 0 up to 2^n−1, with n set to 6, 7 or 8, and then returns to 0. An output flip-flop inverts once when the count equals the active compare value and once at the wrap. The result is one high phase and one low phase in every period, and the compare value sets where the edge falls inside the period.

Software programs the block through a small write port. Address 0 holds the compare value. Address 1 holds the control word. Address 2 takes flip-flop commands. Address 3 has no effect. The compare register can be double-buffered, so that a new duty value only takes effect at a period boundary and no period is cut short. The counter advances only on one of three externally supplied prescaled clock enables. A status output reports a setup that cannot give a proper waveform.

Top module: `pwm_cmp_timer`

## Requirements
- R1: After reset the output level, the match pulse and the period pulse are all 0. The counter is stopped. The compare value, its buffer and the control word are 0.
- R2: The control field per_sel (bits 1:0 of the address-1 word) selects the top count: 01 gives 63, 10 gives 127 and 11 gives 255. On a count tick where the counter is at or above the top count, the counter returns to 0 and period_pulse is high for one cycle on the next cycle.
- R3: On a count tick where the counter equals the active compare value, the output flip-flop inverts, provided the invert-enable bit (bit 6) is set.
- R4: The output flip-flop also inverts on a count tick that wraps the counter. When a match and a wrap fall on the same tick, it inverts only once.
- R5: On each count tick where the counter equals the active compare value, match_irq is high for one cycle on the next cycle. This also happens when the same tick wraps the counter.
- R6: When buffer-enable (bit 5) is set, a write to address 0 fills only the buffer, and the active compare value loads from the buffer on a wrap tick. When bit 5 is clear, a write to address 0 sets the active compare value directly.
- R7: The field clk_sel (bits 3:2) selects the count tick: 00 selects en_div1, 01 selects en_div4, 10 selects en_div16, and 11 selects no source, so counting pauses.
- R8: While run (bit 4) is clear, the counter is held at 0 and neither pulse output is raised.
- R9: cfg_err is high whenever the active compare value is 0, or is at or above the top count, or per_sel is 00. With per_sel at 00 the counter uses the full 8-bit range.
- R10: While bit 6 is clear, the output level does not change on a match or a wrap.
- R11: A write to address 2 with code 10 sets the output to 1, and code 01 clears it to 0. Such a command takes priority over an inversion in the same cycle. Codes 00 and 11 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_div1 | input | 1 | Prescaled enable, every cycle |
| en_div4 | input | 1 | Prescaled enable, one cycle in four |
| en_div16 | input | 1 | Prescaled enable, one cycle in sixteen |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 compare, 1 control, 2 flip-flop command |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output level |
| match_irq | output | 1 | One-cycle pulse after a compare match |
| period_pulse | output | 1 | One-cycle pulse after a wrap |
| cfg_err | output | 1 | Invalid setup status |

## Verification
The assertions check four things on every cycle. The counter is 0 after every wrap and whenever run is clear, and the pulses stay quiet while the timer is stopped. The buffer transfers at a wrap and a direct write is taken at once. The output level holds when no inversion or command is due, and flips exactly once on a coincident match and wrap. Only the bench scenarios can show the rest: the actual period length for each per_sel, the tick rate for each clock source, the waveform position for a given duty value, when a buffered value first takes effect, and the cfg_err decisions. The bench checks these against a cycle model built from the requirements.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

   // Control word written at address 1 (bit 6 down to bit 0)
   typedef struct packed {
      logic       inv_en;
      logic       buf_en;
      logic       run;
      logic [1:0] clk_sel;
      logic [1:0] per_sel;
   } pwmt_ctrl_t;

   localparam int unsigned CTRL_W = $bits(pwmt_ctrl_t);

   localparam logic [1:0] ADDR_CMP   = 2'd0;
   localparam logic [1:0] ADDR_CTRL  = 2'd1;
   localparam logic [1:0] ADDR_FFCMD = 2'd2;

   localparam logic [1:0] FFCMD_CLR = 2'b01;
   localparam logic [1:0] FFCMD_SET = 2'b10;

endpackage

// File: rtl/pwmt_tick_sel.sv
module pwmt_tick_sel #(
   parameter int unsigned NSRC  = 3,
   parameter int unsigned SEL_W = 2
) (
   input  logic [NSRC-1:0]  en_vec,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned NSLOT = 1 << SEL_W;

   if (NSRC > NSLOT) begin : g_chk
      $error("pwmt_tick_sel: more sources than select codes");
   end

   logic [NSLOT-1:0] slot;

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      if (i < NSRC) begin : g_src
         assign slot[i] = en_vec[i];
      end else begin : g_none
         assign slot[i] = 1'b0;
      end
   end

   assign tick = slot[sel];
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [1:0]       per_sel,
   input  logic [CNT_W-1:0] cmp_act,
   output logic [CNT_W-1:0] top,
   output logic             match_evt,
   output logic             ovf_evt
);
   localparam int unsigned NMODE = 4;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] top_tab [NMODE];

   for (genvar m = 0; m < NMODE; m++) begin : g_top
      if (m == 0) begin : g_full
         assign top_tab[m] = '1;
      end else begin : g_pow
         localparam int unsigned TOPV = (1 << (CNT_W - 3 + m)) - 1;
         assign top_tab[m] = TOPV[CNT_W-1:0];
      end
   end

   assign top       = top_tab[per_sel];
   assign match_evt = run && tick && (cnt == cmp_act);
   assign ovf_evt   = run && tick && (cnt >= top);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run)         cnt <= '0;
      else if (ovf_evt)      cnt <= '0;
      else if (tick)         cnt <= cnt + 1'b1;
   end

   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0)); // R8
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> (cnt == '0)); // R2
endmodule

// File: rtl/pwmt_cmp_buf.sv
module pwmt_cmp_buf #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_cmp,
   input  logic [CNT_W-1:0] wdata,
   input  logic             buf_en,
   input  logic             ovf_evt,
   output logic [CNT_W-1:0] cmp_act
);
   logic [CNT_W-1:0] cmp_buf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_buf <= '0;
         cmp_act <= '0;
      end else begin
         if (wr_cmp) cmp_buf <= wdata;
         if (wr_cmp && !buf_en)      cmp_act <= wdata;
         else if (ovf_evt && buf_en) cmp_act <= cmp_buf;
      end
   end

   AST_BUF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && buf_en && !wr_cmp) |=> (cmp_act == $past(cmp_buf))); // R6
   AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmp && !buf_en) |=> (cmp_act == $past(wdata))); // R6
endmodule

// File: rtl/pwmt_out_ff.sv
module pwmt_out_ff
   import pwmt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr,
   input  logic [1:0] cmd,
   input  logic       inv_en,
   input  logic       match_evt,
   input  logic       ovf_evt,
   output logic       ff
);
   logic do_set, do_clr, do_inv;

   assign do_set = cmd_wr && (cmd == FFCMD_SET);
   assign do_clr = cmd_wr && (cmd == FFCMD_CLR);
   assign do_inv = inv_en && (match_evt || ovf_evt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ff <= 1'b0;
      else if (do_set) ff <= 1'b1;
      else if (do_clr) ff <= 1'b0;
      else if (do_inv) ff <= ~ff;
   end

   AST_FF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_wr && !(match_evt || ovf_evt)) |=> $stable(ff)); // R10
   AST_FF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_wr && !inv_en) |=> $stable(ff)); // R10
   AST_FF_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_wr && inv_en && match_evt && ovf_evt) |=> (ff != $past(ff))); // R4
endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
   import pwmt_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_div1,
   input  logic             en_div4,
   input  logic             en_div16,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_out,
   output logic             match_irq,
   output logic             period_pulse,
   output logic             cfg_err
);
   if (CNT_W < CTRL_W || CNT_W > 16) begin : g_chk
      $error("pwm_cmp_timer: CNT_W must lie between the control width and 16");
   end

   pwmt_ctrl_t       ctrl_q;
   logic             tick, match_evt, ovf_evt;
   logic             wr_cmp, wr_ctrl, wr_ffcmd;
   logic [CNT_W-1:0] cmp_act, top;

   assign wr_cmp   = wr_en && (wr_addr == ADDR_CMP);
   assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
   assign wr_ffcmd = wr_en && (wr_addr == ADDR_FFCMD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= pwmt_ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   pwmt_tick_sel #(.NSRC(3), .SEL_W(2)) i_tick (
      .en_vec ({en_div16, en_div4, en_div1}),
      .sel    (ctrl_q.clk_sel),
      .tick   (tick)
   );

   pwmt_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (ctrl_q.run),
      .tick      (tick),
      .per_sel   (ctrl_q.per_sel),
      .cmp_act   (cmp_act),
      .top       (top),
      .match_evt (match_evt),
      .ovf_evt   (ovf_evt)
   );

   pwmt_cmp_buf #(.CNT_W(CNT_W)) i_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_cmp  (wr_cmp),
      .wdata   (wr_data),
      .buf_en  (ctrl_q.buf_en),
      .ovf_evt (ovf_evt),
      .cmp_act (cmp_act)
   );

   pwmt_out_ff i_ff (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (wr_ffcmd),
      .cmd       (wr_data[1:0]),
      .inv_en    (ctrl_q.inv_en),
      .match_evt (match_evt),
      .ovf_evt   (ovf_evt),
      .ff        (pwm_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_irq    <= 1'b0;
         period_pulse <= 1'b0;
      end else begin
         match_irq    <= match_evt;
         period_pulse <= ovf_evt;
      end
   end

   assign cfg_err = (cmp_act == '0) || (cmp_act >= top) || (ctrl_q.per_sel == 2'b00);

   AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.run |=> (!match_irq && !period_pulse)); // R8
   AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> (!match_irq && !period_pulse)); // R7
endmodule

// File: tb/test_pwm_cmp_timer.sv
module test_pwm_cmp_timer;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en_div1, en_div4, en_div16;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_addr = '0;
   logic [CNT_W-1:0] wr_data = '0;
   logic             pwm_out, match_irq, period_pulse, cfg_err;
   logic [3:0]       pc = '0;

   pwm_cmp_timer #(.CNT_W(CNT_W)) i_pwm_cmp_timer (
      .clk(clk), .rst_n(rst_n), .en_div1(en_div1), .en_div4(en_div4),
      .en_div16(en_div16), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pwm_out(pwm_out), .match_irq(match_irq), .period_pulse(period_pulse),
      .cfg_err(cfg_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) pc <= pc + 1'b1;
   assign en_div1  = 1'b1;
   assign en_div4  = (pc[1:0] == 2'd0);
   assign en_div16 = (pc == 4'd0);

   typedef struct { logic pwm; logic irq; logic per; logic err; } exp_t;
   exp_t  q[$];
   string cur_req = "R1";
   int    checks = 0;
   int    errors = 0;

   // Cycle model written from the requirements
   logic [7:0] m_cnt, m_act, m_buf;
   logic [6:0] m_ctrl;
   logic       m_ff, m_irq, m_per;

   function automatic logic [7:0] top_of(input logic [1:0] ps);
      case (ps)
         2'b01:   return 8'd63;
         2'b10:   return 8'd127;
         default: return 8'd255;
      endcase
   endfunction

   always @(posedge clk) begin
      logic       tk, mt, ov;
      logic [7:0] tp;
      exp_t       e;
      if (!rst_n) begin
         m_cnt = 0; m_act = 0; m_buf = 0; m_ctrl = 0;
         m_ff = 0; m_irq = 0; m_per = 0;
      end else begin
         tp = top_of(m_ctrl[1:0]);
         case (m_ctrl[3:2])                       // R7 source choice
            2'b00:   tk = en_div1;
            2'b01:   tk = en_div4;
            2'b10:   tk = en_div16;
            default: tk = 1'b0;
         endcase
         tk = tk && m_ctrl[4];
         mt = tk && (m_cnt == m_act);
         ov = tk && (m_cnt >= tp);
         if (wr_en && wr_addr == 2'd2 && wr_data[1:0] == 2'b10)      m_ff = 1'b1;
         else if (wr_en && wr_addr == 2'd2 && wr_data[1:0] == 2'b01) m_ff = 1'b0;
         else if (m_ctrl[6] && (mt || ov))                           m_ff = ~m_ff;
         if (!m_ctrl[4] || ov) m_cnt = 0;
         else if (tk)          m_cnt = m_cnt + 1;
         if (wr_en && wr_addr == 2'd0 && !m_ctrl[5]) m_act = wr_data;
         else if (ov && m_ctrl[5])                   m_act = m_buf;
         if (wr_en && wr_addr == 2'd0) m_buf = wr_data;
         if (wr_en && wr_addr == 2'd1) m_ctrl = wr_data[6:0];
         m_irq = mt;
         m_per = ov;
      end
      e.pwm = m_ff; e.irq = m_irq; e.per = m_per;
      e.err = (m_act == 0) || (m_act >= top_of(m_ctrl[1:0])) || (m_ctrl[1:0] == 2'b00);
      q.push_back(e);
   end

   task automatic cmp1(input string fld, input logic act, input logic exp);
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_req, fld, act, exp, $time);
      end
   endtask

   // Monitor: pops the expectation for the edge just passed
   always @(negedge clk) begin
      exp_t e;
      if (q.size() > 0) begin
         e = q.pop_front();
         checks++;
         cmp1("pwm_out (R3 R4 R10 R11)", pwm_out, e.pwm);
         cmp1("match_irq (R5)", match_irq, e.irq);
         cmp1("period_pulse (R2)", period_pulse, e.per);
         cmp1("cfg_err (R9)", cfg_err, e.err);
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      cur_req = "R1";
      idle(3);
      rst_n = 1'b1;
      idle(6);
      checks++;                                   // R1 direct reset check
      if (pwm_out !== 1'b0 || match_irq !== 1'b0 || period_pulse !== 1'b0) begin
         errors++;
         $display("FAIL R1 outputs actual=%0b%0b%0b expected=000", pwm_out, match_irq, period_pulse);
      end
      // control: bit6 inv_en, bit5 buf_en, bit4 run, bits3:2 clk_sel, bits1:0 per_sel
      cur_req = "R2 R3"; wr(2'd0, 8'd20); wr(2'd1, 8'h51); idle(200);
      cur_req = "R2";    wr(2'd1, 8'h52); idle(300);
      cur_req = "R4";    wr(2'd1, 8'h53); idle(550);
      cur_req = "R7";    wr(2'd1, 8'h57); idle(600);
      wr(2'd1, 8'h5B); idle(2200);
      wr(2'd1, 8'h5F); idle(100);
      cur_req = "R6";    wr(2'd1, 8'h71); wr(2'd0, 8'd40); idle(150);
      wr(2'd0, 8'd10); idle(150);
      cur_req = "R9";    wr(2'd1, 8'h51); wr(2'd0, 8'd0); idle(80);
      cur_req = "R5";    wr(2'd0, 8'd63); idle(150);
      cur_req = "R9";    wr(2'd0, 8'd70); idle(80);
      wr(2'd0, 8'd20); wr(2'd1, 8'h50); idle(300);
      cur_req = "R10";   wr(2'd1, 8'h11); idle(200);
      cur_req = "R11";   wr(2'd1, 8'h51); wr(2'd2, 8'h02); idle(30);
      wr(2'd2, 8'h01); idle(30);
      wr(2'd2, 8'h03); idle(30);
      wr(2'd2, 8'h00); idle(30);
      wr(2'd3, 8'h55); idle(30);
      cur_req = "R8";    wr(2'd1, 8'h41); idle(100);
      wr(2'd1, 8'h51); idle(60);
      idle(2);
      finish_run();
   end
endmodule